// File: doc/BRIEF.md
# Scan-Line Compare Interrupt Source

This block counts clocks along each scan line and scan lines within each frame. It raises a latched interrupt cause when the line count reaches a value that software has programmed. Other causes are latched in the same way: the start of each frame, and a parameterised number of external event strobes. Each cause sits in a status register until software clears it by writing a one to its bit. A separate enable register decides which latched causes pull the shared request line.

The request output `irq_n_o` is active low. It is meant to be combined with the requests of other devices on one line that is low when any device pulls it. An interrupt handler reads the status register to learn whether this device is asking for service. It then acknowledges by writing the value it read back to the same register. The register interface is a plain synchronous port with address, write data, write strobe, read strobe and read data. It has no back-pressure: every access completes in the cycle it is strobed.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset all status flags, the enable register and the compare value are zero, `irq_n_o` is high and the line counter is 0.
- R2: The line counter holds for `CLKS_PER_LINE` clocks, then advances by one. After `LINES_PER_FRAME-1` it wraps to 0. It reads at address 4 (low byte) and address 5 (high byte) and never exceeds `LINES_PER_FRAME-1`.
- R3: Status bit 0 (line match) sets only on the first clock of the line whose number equals the compare value, which is written at address 2 (low byte) and address 3 (high byte). Programming the compare value to the current line after that first clock does not set the flag during that line.
- R4: With bit 0 enabled and acknowledged after each request, a line-match request recurs once per frame, `LINES_PER_FRAME*CLKS_PER_LINE` clocks apart.
- R5: Status bit 1 sets on the first clock of line 0. Status bit 2+k sets in any clock where `ext_evt_i[k]` is high.
- R6: A flag stays set until a write to address 0 has a one in that bit position. Zero bits in that write leave flags unchanged, and bit 7 of the write has no effect.
- R7: If a cause's event and a clear of its bit fall in the same clock, the flag ends up set.
- R8: The enable register is at address 1, separate from the status register. Writing it never changes a flag, and clearing a flag never changes the enable register.
- R9: `irq_n_o` is low exactly when some flag and its enable bit are both one. Enabling an already-latched flag drives it low in the clock after the write.
- R10: A read of address 0 returns the flags in bits N_CAUSES-1..0 and, in bit 7, the OR over all causes of flag AND enable. Read data is registered and appears in the clock after `rd_en_i`.
- R11: Writing back the value just read from address 0 clears every flag that the read showed as set and releases `irq_n_o` if no other cause is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| ext_evt_i | input | N_CAUSES-2 | External event strobes, one per extra cause |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The line-match function is tried with several input patterns. Compare lines ahead of the current position give a fixed interval from the frame-start request, which separates correct line matching from an off-by-one count. Leaving the cause enabled across frames separates a once-per-frame period from a wrong wrap point. Writing the compare value to the current line mid-line separates a first-clock-only match from a level match. The status register is driven with single-bit, zero, foreign-bit and read-back writes, and with a clear in the same clock as an event. These patterns separate true write-one-to-clear from write-anything clearing and from clear-over-event priority.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_STAT    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_ENABLE  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CMP_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CMP_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_LINE_LO = 3'd4;
  localparam logic [ADDR_W-1:0] REG_LINE_HI = 3'd5;

  localparam int unsigned CAUSE_MATCH = 0;
  localparam int unsigned CAUSE_FRAME = 1;
  localparam int unsigned CAUSE_EXT0  = 2;
endpackage

// File: rtl/scanirq_timing.sv
module scanirq_timing #(
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned CLKS_PER_LINE   = 63,
  parameter int unsigned LINE_W          = 9,
  parameter int unsigned DOT_W           = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              line_start_o,
  output logic              frame_start_o
);
  localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(CLKS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);

  logic [DOT_W-1:0]  dot_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (dot_q == LAST_DOT) begin
      dot_q  <= '0;
      line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
    end else begin
      dot_q  <= dot_q + 1'b1;
    end
  end

  assign dot_o         = dot_q;
  assign line_o        = line_q;
  assign line_start_o  = (dot_q == '0);
  assign frame_start_o = line_start_o && (line_q == '0);
endmodule

// File: rtl/scanirq_compare.sv
module scanirq_compare #(
  parameter int unsigned LINE_W = 9,
  parameter int unsigned CMP_W  = 16
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              line_start_i,
  input  logic [CMP_W-1:0]  cmp_i,
  output logic              match_o
);
  logic [CMP_W-1:0] line_ext;
  assign line_ext = {{(CMP_W-LINE_W){1'b0}}, line_i};
  // Pulses only on the opening clock of the line
  assign match_o  = line_start_i && (line_ext == cmp_i);
endmodule

// File: rtl/scanirq_regs.sv
module scanirq_regs
  import scanirq_pkg::*;
#(
  parameter int unsigned N_CAUSES = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LINE_W   = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [N_CAUSES-1:0] evt_i,
  input  logic [LINE_W-1:0]   line_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [2*DATA_W-1:0] cmp_o,
  output logic [N_CAUSES-1:0] flags_o,
  output logic [N_CAUSES-1:0] enable_o,
  output logic                pending_o
);
  localparam int unsigned CMP_W = 2 * DATA_W;

  logic                wr_stat;
  logic [N_CAUSES-1:0] flags_q;
  logic [N_CAUSES-1:0] enable_q;
  logic [CMP_W-1:0]    cmp_q;
  logic [CMP_W-1:0]    line_ext;
  logic [DATA_W-1:0]   stat_view;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;

  assign wr_stat = wr_en_i && (addr_i == REG_STAT);

  // One sticky flag per cause; an event beats a same-cycle clear
  for (genvar i = 0; i < N_CAUSES; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     flags_q[i] <= 1'b0;
      else if (evt_i[i])               flags_q[i] <= 1'b1;
      else if (wr_stat && wdata_i[i])  flags_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      cmp_q    <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_ENABLE: enable_q             <= wdata_i[N_CAUSES-1:0];
        REG_CMP_LO: cmp_q[DATA_W-1:0]    <= wdata_i;
        REG_CMP_HI: cmp_q[CMP_W-1:DATA_W] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign pending_o = |(flags_q & enable_q);
  assign line_ext  = {{(CMP_W-LINE_W){1'b0}}, line_i};

  always_comb begin
    stat_view                 = '0;
    stat_view[N_CAUSES-1:0]   = flags_q;
    stat_view[DATA_W-1]       = pending_o;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_STAT:    rd_mux = stat_view;
      REG_ENABLE:  rd_mux[N_CAUSES-1:0] = enable_q;
      REG_CMP_LO:  rd_mux = cmp_q[DATA_W-1:0];
      REG_CMP_HI:  rd_mux = cmp_q[CMP_W-1:DATA_W];
      REG_LINE_LO: rd_mux = line_ext[DATA_W-1:0];
      REG_LINE_HI: rd_mux = line_ext[CMP_W-1:DATA_W];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign cmp_o    = cmp_q;
  assign flags_o  = flags_q;
  assign enable_o = enable_q;
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import scanirq_pkg::*;
#(
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned CLKS_PER_LINE   = 63,
  parameter int unsigned N_CAUSES        = 4,
  parameter int unsigned DATA_W          = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [N_CAUSES-3:0] ext_evt_i,
  output logic                irq_n_o
);
  localparam int unsigned LINE_W = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1;
  localparam int unsigned DOT_W  = (CLKS_PER_LINE > 1) ? $clog2(CLKS_PER_LINE) : 1;
  localparam int unsigned CMP_W  = 2 * DATA_W;
  localparam int unsigned N_EXT  = N_CAUSES - CAUSE_EXT0;

  logic [DOT_W-1:0]    dot;
  logic [LINE_W-1:0]   line;
  logic                line_start;
  logic                frame_start;
  logic                match;
  logic [CMP_W-1:0]    cmp;
  logic [N_CAUSES-1:0] evt;
  logic [N_CAUSES-1:0] flags;
  logic [N_CAUSES-1:0] enable;
  logic                pending;

  scanirq_timing #(
    .LINES_PER_FRAME(LINES_PER_FRAME), .CLKS_PER_LINE(CLKS_PER_LINE),
    .LINE_W(LINE_W), .DOT_W(DOT_W)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .dot_o(dot), .line_o(line),
    .line_start_o(line_start), .frame_start_o(frame_start)
  );

  scanirq_compare #(.LINE_W(LINE_W), .CMP_W(CMP_W)) u_cmp (
    .line_i(line), .line_start_i(line_start), .cmp_i(cmp), .match_o(match)
  );

  assign evt[CAUSE_MATCH] = match;
  assign evt[CAUSE_FRAME] = frame_start;
  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    assign evt[CAUSE_EXT0 + k] = ext_evt_i[k];
  end

  scanirq_regs #(.N_CAUSES(N_CAUSES), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .evt_i(evt), .line_i(line),
    .rdata_o(rdata_o), .cmp_o(cmp), .flags_o(flags), .enable_o(enable),
    .pending_o(pending)
  );

  assign irq_n_o = ~pending;
endmodule

// File: rtl/scanirq_checker.sv
module scanirq_checker
  import scanirq_pkg::*;
#(
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned CLKS_PER_LINE   = 63,
  parameter int unsigned N_CAUSES        = 4,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned LINE_W          = 9,
  parameter int unsigned DOT_W           = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                wr_en_i,
  input logic [N_CAUSES-1:0] evt,
  input logic [N_CAUSES-1:0] flags,
  input logic [N_CAUSES-1:0] enable,
  input logic [LINE_W-1:0]   line,
  input logic [DOT_W-1:0]    dot
);
  logic stat_wr;
  assign stat_wr = wr_en_i && (addr_i == REG_STAT);

  assert_line_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line <= LINE_W'(LINES_PER_FRAME - 1));

  assert_line_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot != DOT_W'(CLKS_PER_LINE - 1)) |=> $stable(line));

  for (genvar i = 0; i < N_CAUSES; i++) begin : g_bit
    assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags[i] && !(stat_wr && wdata_i[i])) |=> flags[i]);
    assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[i] |=> flags[i]);
  end

  assert_enable_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> $stable(enable));
endmodule

bind scanline_irq_unit scanirq_checker #(
  .LINES_PER_FRAME(LINES_PER_FRAME), .CLKS_PER_LINE(CLKS_PER_LINE),
  .N_CAUSES(N_CAUSES), .DATA_W(DATA_W), .LINE_W(LINE_W), .DOT_W(DOT_W)
) u_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_en_i(wr_en_i), .evt(evt), .flags(flags), .enable(enable),
  .line(line), .dot(dot)
);

// File: tb/scanline_irq_unit_test.sv
module scanline_irq_unit_test;
  localparam int LINES = 10;
  localparam int CLKS  = 8;
  localparam int FRAME = LINES * CLKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic [1:0] ext = '0;
  logic       irq_n;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  scanline_irq_unit #(.LINES_PER_FRAME(LINES), .CLKS_PER_LINE(CLKS),
                      .N_CAUSES(4), .DATA_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
    .ext_evt_i(ext), .irq_n_o(irq_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_ext(input int k);
    @(negedge clk); ext[k] = 1'b1;
    @(negedge clk); ext[k] = 1'b0;
  endtask

  task automatic wait_irq(output int t);
    int guard = 0;
    @(negedge clk);
    while (irq_n && guard < 1000) begin @(negedge clk); guard++; end
    t = cyc;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(irq_n === 1'b1, "R1 irq_n in reset", irq_n, 1);
    @(negedge clk); rst_n = 1'b1;
    chk(irq_n === 1'b1, "R1 irq_n after reset", irq_n, 1);
    rd(3'd1, v); chk(v == 8'h00, "R1 enable reset", v, 0);
    rd(3'd2, v); chk(v == 8'h00, "R1 compare reset", v, 0);
    rd(3'd0, v); chk((v & 8'h8C) == 8'h00, "R1 status reset", v & 8'h8C, 0);
  endtask

  task automatic t_line();
    logic [7:0] v;
    for (int i = 0; i < 25; i++) begin
      rd(3'd4, v);
      chk(v < LINES, "R2 line in range", v, LINES - 1);
    end
    rd(3'd5, v); chk(v == 8'h00, "R2 line high byte", v, 0);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    pulse_ext(0);
    chk(irq_n === 1'b1, "R9 latched but disabled", irq_n, 1);
    rd(3'd0, v);
    chk(v[2] == 1'b1, "R5 ext flag set", v[2], 1);
    chk(v[7] == 1'b0, "R10 pending clear when disabled", v[7], 0);
    wr(3'd1, 8'h04);
    chk(irq_n === 1'b0, "R9 enable asserts at once", irq_n, 0);
    rd(3'd0, v);
    chk(v[2] == 1'b1, "R8 enable keeps flag", v[2], 1);
    chk(v[7] == 1'b1, "R10 pending bit", v[7], 1);
    repeat (20) @(negedge clk);
    chk(irq_n === 1'b0, "R6 request held", irq_n, 0);
    wr(3'd0, 8'h00);
    chk(irq_n === 1'b0, "R6 zero write no clear", irq_n, 0);
    wr(3'd0, 8'h88);
    chk(irq_n === 1'b0, "R6 other bits no clear", irq_n, 0);
    wr(3'd0, 8'h04);
    chk(irq_n === 1'b1, "R6 w1c releases", irq_n, 1);
    rd(3'd1, v);
    chk(v == 8'h04, "R8 clear keeps enable", v, 4);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    pulse_ext(0);
    @(negedge clk); ext[0] = 1'b1; addr = 3'd0; wdata = 8'h04; wr_en = 1'b1;
    @(negedge clk); ext[0] = 1'b0; wr_en = 1'b0;
    rd(3'd0, v);
    chk(v[2] == 1'b1, "R7 event beats clear", v[2], 1);
    wr(3'd0, 8'h04);
    rd(3'd0, v);
    chk(v[2] == 1'b0, "R6 plain clear", v[2], 0);
  endtask

  task automatic t_rmw();
    logic [7:0] v;
    pulse_ext(0); pulse_ext(1);
    wr(3'd1, 8'h0C);
    chk(irq_n === 1'b0, "R9 two causes", irq_n, 0);
    rd(3'd0, v);
    chk((v & 8'h8C) == 8'h8C, "R10 status view", v & 8'h8C, 8'h8C);
    wr(3'd0, v);
    chk(irq_n === 1'b1, "R11 write-back releases", irq_n, 1);
    rd(3'd0, v);
    chk((v & 8'h0C) == 8'h00, "R11 flags cleared", v & 8'h0C, 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_raster();
    logic [7:0] v;
    int t0, t1, t2, t3;
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h05);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h03);
    wait_irq(t0);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h03);
    wait_irq(t1);
    chk(t1 - t0 == 5 * CLKS, "R3 match offset from frame start (R5)", t1 - t0, 5 * CLKS);
    rd(3'd4, v);
    chk(v == 8'h05, "R3 request on compare line", v, 5);
    wr(3'd0, 8'h01);
    wait_irq(t2);
    chk(t2 - t1 == FRAME, "R4 once per frame", t2 - t1, FRAME);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h00);
    wr(3'd2, 8'h05);
    wait_irq(t3);
    chk(t3 - t2 == FRAME, "R3 mid-line compare write no match", t3 - t2, FRAME);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_line();
    t_sticky();
    t_priority();
    t_rmw();
    t_raster();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule